// File: doc/BRIEF.md
# Magic Packet Wake-up Detector

This block watches a byte-wide Ethernet receive stream for a wake-up frame. A valid wake-up frame carries, somewhere after its two address fields, a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the 48-bit station address. When the detector finds one, it sets a sticky flag. That flag can be routed to a host interrupt, to a power-event output, or to both.

Only frames that the node would accept are examined. These are frames whose destination is the station address, and group-addressed frames, which include broadcast. The matcher resynchronises on every break. A wrong byte during the address copies sends it back to hunting for the 0xFF run, still within the same frame. While detection is enabled, normal byte delivery to the rest of the receive path is suppressed. Clearing the enable restores it.

Top module: `magic_wake_detect`

## Requirements
- R1: While `enable_i` is 1, `rx_valid_o` stays 0 and detection runs. While it is 0, `rx_valid_o` follows `byte_valid_i` and no detection can occur.
- R2: A frame is examined only when its destination qualifies. It qualifies when it equals the station address, or when bit 0 of its first byte is 1 (group address, which covers broadcast FF:FF:FF:FF:FF:FF). Any other frame never causes detection.
- R3: The first 12 bytes of a frame (destination and source) are never searched, even when they hold 0xFF bytes.
- R4: A sync run needs at least six consecutive 0xFF bytes. Five are not enough.
- R5: After the sync run, sixteen unbroken copies of the station address must follow. Each copy is sent most significant byte first (bits 47:40 first). Fifteen copies are not enough.
- R6: A mismatch during the copies returns the matcher to sync hunting within the same frame. If the mismatching byte is 0xFF, it counts as the first byte of a new sync run.
- R7: More than six consecutive 0xFF bytes keep the matcher synchronised, so the copies may begin after any longer run.
- R8: `detected_o` rises on the clock edge that accepts the final address byte. It is sticky until `clear_i` is pulsed. A new detection in the same cycle as `clear_i` wins.
- R9: `irq_o` is `detected_o` gated by `irq_en_i`, and `pme_o` is `detected_o` gated by `pme_en_i`.
- R10: Each start-of-frame resets the pattern state. Bytes that arrive after end-of-frame and before the next start-of-frame are ignored.
- R11: After reset, `detected_o`, `irq_o` and `pme_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Detection enable; suppresses normal delivery |
| irq_en_i | input | 1 | Route detection to `irq_o` |
| pme_en_i | input | 1 | Route detection to `pme_o` |
| station_addr_i | input | 48 | Station address, bits 47:40 first on the wire |
| byte_valid_i | input | 1 | Receive byte valid |
| byte_i | input | 8 | Receive byte |
| sof_i | input | 1 | First byte of frame (with `byte_valid_i`) |
| eof_i | input | 1 | Last byte of frame (with `byte_valid_i`) |
| clear_i | input | 1 | Write-one-to-clear of the sticky flag |
| detected_o | output | 1 | Sticky wake-up frame received flag |
| irq_o | output | 1 | Host interrupt request |
| pme_o | output | 1 | Power-management event |
| rx_valid_o | output | 1 | Byte valid passed on to normal reception |

## Verification
The directed tests go after the points where the run counts are easy to get wrong. Five sync bytes or fifteen copies must not trigger detection; a counter off by one would wake the host on a frame that is not a wake-up frame. A 0xFF sync run placed in the source address must be ignored; a design that searched the header would detect there. Two breaks are tested, one with an ordinary byte and one with 0xFF, each followed by a fresh pattern in the same frame. A design that gave up on the frame, or that dropped the 0xFF as a sync start, would miss the wake-up. Stray bytes after end-of-frame and a restart at start-of-frame are also tested, so that a matcher carrying state across frames would be caught.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int unsigned MAC_BYTES = 6;
    localparam logic [7:0]  SYNC_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PAT_HUNT = 2'd0,
        PAT_REPS = 2'd1,
        PAT_DONE = 2'd2
    } pat_mode_e;

endpackage

// File: rtl/mwd_addr_qual.sv
module mwd_addr_qual #(
    parameter int unsigned ADDR_BYTES = mwd_pkg::MAC_BYTES,
    parameter int unsigned HDR_BYTES  = 2 * ADDR_BYTES
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    byte_valid_i,
    input  logic [7:0]              byte_i,
    input  logic                    sof_i,
    input  logic                    eof_i,
    input  logic [8*ADDR_BYTES-1:0] station_i,
    output logic                    payload_o
);
    localparam int unsigned CW = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          own;
        logic          grp;
        logic          in_frame;
    } qual_t;

    qual_t q_q, q_d;
    logic [CW-1:0] sel;
    logic [7:0]    own_byte;

    always_comb begin
        sel      = (q_q.cnt < CW'(ADDR_BYTES)) ? q_q.cnt : '0;
        own_byte = station_i[(ADDR_BYTES - 1 - int'(sel)) * 8 +: 8];
        q_d      = q_q;
        if (byte_valid_i) begin
            if (sof_i) begin
                q_d.cnt      = CW'(1);
                q_d.own      = (byte_i == station_i[(ADDR_BYTES - 1) * 8 +: 8]);
                q_d.grp      = byte_i[0];
                q_d.in_frame = ~eof_i;
            end else if (q_q.in_frame) begin
                if (q_q.cnt < CW'(ADDR_BYTES)) begin
                    q_d.own = q_q.own & (byte_i == own_byte);
                end
                if (q_q.cnt < CW'(HDR_BYTES)) begin
                    q_d.cnt = q_q.cnt + CW'(1);
                end
                q_d.in_frame = ~eof_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign payload_o = byte_valid_i & ~sof_i & q_q.in_frame &
                       (q_q.cnt == CW'(HDR_BYTES)) & (q_q.own | q_q.grp);

endmodule

// File: rtl/mwd_pattern.sv
module mwd_pattern
    import mwd_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = MAC_BYTES,
    parameter int unsigned SYNC_LEN   = 6,
    parameter int unsigned REP_COUNT  = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    restart_i,
    input  logic                    step_i,
    input  logic [7:0]              byte_i,
    input  logic [8*ADDR_BYTES-1:0] station_i,
    output logic                    hit_o
);
    localparam int unsigned SW = $clog2(SYNC_LEN + 1);
    localparam int unsigned BW = $clog2(ADDR_BYTES);
    localparam int unsigned RW = $clog2(REP_COUNT);

    typedef struct packed {
        pat_mode_e     mode;
        logic [SW-1:0] ff_cnt;
        logic [BW-1:0] idx;
        logic [RW-1:0] rep;
    } pat_t;

    pat_t p_q, p_d;
    logic [7:0] want;
    logic [7:0] first;
    logic       is_sync;

    always_comb begin
        want    = station_i[(ADDR_BYTES - 1 - int'(p_q.idx)) * 8 +: 8];
        first   = station_i[(ADDR_BYTES - 1) * 8 +: 8];
        is_sync = (byte_i == SYNC_BYTE);
        p_d     = p_q;
        hit_o   = 1'b0;
        if (restart_i) begin
            p_d = '0;
        end else if (step_i) begin
            unique case (p_q.mode)
                PAT_HUNT: begin
                    if (p_q.ff_cnt == SW'(SYNC_LEN) && byte_i == first) begin
                        p_d.mode = PAT_REPS;
                        p_d.idx  = BW'(1);
                        p_d.rep  = '0;
                    end else if (is_sync) begin
                        if (p_q.ff_cnt != SW'(SYNC_LEN)) p_d.ff_cnt = p_q.ff_cnt + SW'(1);
                    end else begin
                        p_d.ff_cnt = '0;
                    end
                end
                PAT_REPS: begin
                    if (byte_i == want) begin
                        if (p_q.idx == BW'(ADDR_BYTES - 1)) begin
                            p_d.idx = '0;
                            if (p_q.rep == RW'(REP_COUNT - 1)) begin
                                hit_o    = 1'b1;
                                p_d.mode = PAT_DONE;
                            end else begin
                                p_d.rep = p_q.rep + RW'(1);
                            end
                        end else begin
                            p_d.idx = p_q.idx + BW'(1);
                        end
                    end else begin
                        p_d.mode   = PAT_HUNT;
                        p_d.ff_cnt = is_sync ? SW'(1) : '0;
                        p_d.idx    = '0;
                        p_d.rep    = '0;
                    end
                end
                default: p_d = p_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect
    import mwd_pkg::*;
#(
    parameter int unsigned SYNC_LEN  = 6,
    parameter int unsigned REP_COUNT = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        enable_i,
    input  logic        irq_en_i,
    input  logic        pme_en_i,
    input  logic [47:0] station_addr_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    input  logic        sof_i,
    input  logic        eof_i,
    input  logic        clear_i,
    output logic        detected_o,
    output logic        irq_o,
    output logic        pme_o,
    output logic        rx_valid_o
);
    typedef struct packed {
        logic detected;
    } stat_t;

    stat_t s_q, s_d;
    logic  payload;
    logic  hit;
    logic  restart;

    mwd_addr_qual #(
        .ADDR_BYTES (MAC_BYTES)
    ) i_qual (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .sof_i        (sof_i),
        .eof_i        (eof_i),
        .station_i    (station_addr_i),
        .payload_o    (payload)
    );

    assign restart = ~enable_i | (byte_valid_i & sof_i);

    mwd_pattern #(
        .ADDR_BYTES (MAC_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .REP_COUNT  (REP_COUNT)
    ) i_pattern (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .step_i    (payload & enable_i),
        .byte_i    (byte_i),
        .station_i (station_addr_i),
        .hit_o     (hit)
    );

    always_comb begin
        s_d.detected = hit | (s_q.detected & ~clear_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign detected_o = s_q.detected;
    assign irq_o      = s_q.detected & irq_en_i;
    assign pme_o      = s_q.detected & pme_en_i;
    assign rx_valid_o = byte_valid_i & ~enable_i;

endmodule

// File: rtl/mwd_checker.sv
module mwd_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic irq_en_i,
    input logic pme_en_i,
    input logic byte_valid_i,
    input logic clear_i,
    input logic detected_o,
    input logic irq_o,
    input logic pme_o,
    input logic rx_valid_o
);
    a_r1_no_delivery_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |-> !rx_valid_o);

    a_r1_detect_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(detected_o) |-> $past(enable_i));

    a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (detected_o && !clear_i) |=> detected_o);

    a_r8_set_by_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(detected_o) |-> $past(byte_valid_i));

    a_r9_irq_routed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (detected_o && irq_en_i));

    a_r9_pme_routed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pme_o |-> (detected_o && pme_en_i));
endmodule

bind magic_wake_detect mwd_checker i_mwd_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .irq_en_i     (irq_en_i),
    .pme_en_i     (pme_en_i),
    .byte_valid_i (byte_valid_i),
    .clear_i      (clear_i),
    .detected_o   (detected_o),
    .irq_o        (irq_o),
    .pme_o        (pme_o),
    .rx_valid_o   (rx_valid_o)
);

// File: tb/test_magic_wake_detect.sv
module test_magic_wake_detect;

    localparam logic [47:0] STA   = 48'h02_A4_C6_18_3B_7D;
    localparam logic [47:0] SRC   = 48'h0A_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h06_10_20_30_40_50;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_FB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        irq_en = 1'b0;
    logic        pme_en = 1'b0;
    logic        valid = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic        clear = 1'b0;
    logic        detected, irq, pme, rx_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] fr[$];
    logic det_before, det_after;

    always #10 clk = ~clk;

    magic_wake_detect i_magic_wake_detect (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (enable),
        .irq_en_i       (irq_en),
        .pme_en_i       (pme_en),
        .station_addr_i (STA),
        .byte_valid_i   (valid),
        .byte_i         (data),
        .sof_i          (sof),
        .eof_i          (eof),
        .clear_i        (clear),
        .detected_o     (detected),
        .irq_o          (irq),
        .pme_o          (pme),
        .rx_valid_o     (rx_valid)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic add_addr(input logic [47:0] a);
        for (int i = 0; i < 6; i++) fr.push_back(a[47-8*i -: 8]);
    endtask

    task automatic add_ff(input int n);
        for (int i = 0; i < n; i++) fr.push_back(8'hFF);
    endtask

    task automatic add_reps(input int n);
        for (int i = 0; i < n; i++) add_addr(STA);
    endtask

    task automatic drive(input bit mark_sof, input bit mark_eof);
        for (int i = 0; i < fr.size(); i++) begin
            @(negedge clk);
            valid = 1'b1;
            data  = fr[i];
            sof   = mark_sof && (i == 0);
            eof   = mark_eof && (i == fr.size() - 1);
            if (i == fr.size() - 1) begin
                #1 det_before = detected;
            end
        end
        @(negedge clk);
        det_after = detected;
        valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'h00;
        fr.delete();
        @(negedge clk);
    endtask

    task automatic frame(input logic [47:0] dst);
        logic [7:0] body[$];
        body = fr;
        fr.delete();
        add_addr(dst);
        add_addr(SRC);
        foreach (body[i]) fr.push_back(body[i]);
        drive(1'b1, 1'b1);
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 detected", detected, 1'b0);
        chk("R11 irq", irq, 1'b0);
        chk("R11 pme", pme, 1'b0);
    endtask

    task automatic t_own();
        enable = 1'b1; irq_en = 1'b1; pme_en = 1'b0;
        add_ff(6); add_reps(16);
        frame(STA);
        chk("R8 not set before final edge", det_before, 1'b0);
        chk("R8 set after final edge", det_after, 1'b1);
        chk("R5 own address detect", detected, 1'b1);
        chk("R9 irq routed", irq, 1'b1);
        chk("R9 pme gated", pme, 1'b0);
    endtask

    task automatic t_sticky_clear();
        add_ff(3); fr.push_back(8'h00);
        frame(OTHER);
        chk("R8 sticky across frames", detected, 1'b1);
        do_clear();
        chk("R8 cleared by strobe", detected, 1'b0);
        chk("R9 irq follows clear", irq, 1'b0);
    endtask

    task automatic t_bcast();
        irq_en = 1'b0; pme_en = 1'b1;
        fr.push_back(8'h42); add_ff(6); add_reps(16);
        frame(BCAST);
        chk("R2 broadcast detect", detected, 1'b1);
        chk("R9 pme routed", pme, 1'b1);
        chk("R9 irq gated", irq, 1'b0);
        do_clear();
    endtask

    task automatic t_mcast();
        add_ff(6); add_reps(16);
        frame(MCAST);
        chk("R2 multicast detect", detected, 1'b1);
        do_clear();
    endtask

    task automatic t_foreign();
        add_ff(6); add_reps(16);
        frame(OTHER);
        chk("R2 foreign unicast ignored", detected, 1'b0);
    endtask

    task automatic t_header();
        add_addr(STA); add_addr(BCAST); add_reps(16);
        drive(1'b1, 1'b1);
        chk("R3 header not searched", detected, 1'b0);
    endtask

    task automatic t_short_sync();
        add_ff(5); add_reps(16);
        frame(STA);
        chk("R4 five sync bytes insufficient", detected, 1'b0);
    endtask

    task automatic t_short_reps();
        add_ff(6); add_reps(15); fr.push_back(8'h00);
        frame(STA);
        chk("R5 fifteen copies insufficient", detected, 1'b0);
    endtask

    task automatic t_resync();
        add_ff(6); add_reps(8); fr.push_back(8'h00);
        add_ff(6); add_reps(16);
        frame(STA);
        chk("R6 resync after plain break", detected, 1'b1);
        do_clear();
    endtask

    task automatic t_ff_break();
        add_ff(6); add_reps(3); fr.push_back(STA[47:40]); fr.push_back(STA[39:32]);
        add_ff(6); add_reps(16);
        frame(STA);
        chk("R6 break byte 0xFF starts sync", detected, 1'b1);
        do_clear();
    endtask

    task automatic t_long_sync();
        add_ff(11); add_reps(16);
        frame(STA);
        chk("R7 long sync run accepted", detected, 1'b1);
        do_clear();
    endtask

    task automatic t_frame_bounds();
        add_ff(6); add_reps(8);
        frame(STA);
        add_reps(8);
        drive(1'b0, 1'b0);
        chk("R10 bytes after eof ignored", detected, 1'b0);
        add_reps(8);
        frame(STA);
        chk("R10 sof resets pattern", detected, 1'b0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        enable = 1'b0; valid = 1'b1; data = 8'h55;
        #1 chk("R1 delivery when disabled", rx_valid, 1'b1);
        @(negedge clk);
        enable = 1'b1;
        #1 chk("R1 delivery blocked when enabled", rx_valid, 1'b0);
        @(negedge clk);
        valid = 1'b0; enable = 1'b0;
        add_ff(6); add_reps(16);
        frame(STA);
        chk("R1 no detect when disabled", detected, 1'b0);
        enable = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_own();
        t_sticky_clear();
        t_bcast();
        t_mcast();
        t_foreign();
        t_header();
        t_short_sync();
        t_short_reps();
        t_resync();
        t_ff_break();
        t_long_sync();
        t_frame_bounds();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule